// File: doc/BRIEF.md
# DMA Descriptor Queue Register Front End

This block is the software-facing control plane of a single-channel DMA engine. Software fills a set of 32-bit staging registers (addresses, lengths, strides, flags) and commits them with a write to a start register. Each committed descriptor gets a transfer ID. It waits in a small hardware queue and is handed to the data mover through a valid/ready handshake. The mover later reports completion by presenting the ID on a done strobe.

Completions collect in a 32-bit mask, one bit per ID. When the queue is full, a reading of 1 from the start register tells software that its last commit has not yet been accepted, so software polls that register for back-pressure. Two interrupt events are recorded in a sticky source register, filtered by a mask and cleared by write-one: a descriptor entering the queue, and a transfer completing. Register reads are combinational and have no side effects. Writes take effect at the clock edge on which `reg_we_i` is sampled high.

Top module: `dmaq_regif`

## Requirements
- R1: After reset, control reads 0, the interrupt mask reads 3, next ID reads 0, the done mask reads 0 and the start register reads 0. Also after reset, `irq_o` and `desc_valid_o` are low, and X length reads the alignment mask (3 by default).
- R2: Register offsets: mask 0x080, pending 0x084, source 0x088, control 0x400, next ID 0x404, start 0x408, flags 0x40C, destination 0x410, source address 0x414, X length 0x418, Y length 0x41C, destination stride 0x420, source stride 0x424, done 0x428, active ID 0x42C. Any other offset reads 0.
- R3: Unsupported bits read back as zero. The two low bits of addresses and strides read 0. Length and stride bits at position 24 and above read 0. The two low X-length bits always read 1. Flags bit 2 (partial report) reads 0 and flags bits 0 (cyclic) and 1 (last) are kept.
- R4: Control bit 0 is enable and bit 1 is pause. A control write with bit 0 clear empties the queue and cancels a waiting commit, but keeps next ID and the done mask. A start write while disabled is ignored.
- R5: A start write with bit 0 set commits the staging registers. The queue holds 4 descriptors. A commit that finds no room keeps the start register reading 1, and the descriptor enters on the edge after a slot frees. With room, it enters on the write edge.
- R6: While enabled and not paused, the queue head is offered on `desc_valid_o` with the fields and ID it had at commit, in commit order. It is removed on an edge where `desc_ready_i` is high. While paused the head is held and `desc_valid_o` is low.
- R7: Next ID returns the ID the next accepted descriptor gets. IDs advance by one per accepted descriptor, wrapping modulo 32.
- R8: `done_valid_i` sets bit `done_id_i` of the done mask. That bit clears when the same ID is given to a new descriptor. Writes to the done register are ignored.
- R9: Active ID returns the ID at the queue head, or next ID when the queue is empty.
- R10: Source bit 0 is set when a descriptor enters the queue, and source bit 1 is set on `done_valid_i`. Pending reads source AND NOT mask. Writing 1s to pending clears those source bits. `irq_o` is the OR of the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset, for reads and writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| desc_valid_o | output | 1 | Queue head offered to the mover |
| desc_ready_i | input | 1 | Mover takes the head |
| desc_id_o | output | 5 | Transfer ID of the head |
| desc_flags_o | output | 3 | Flags of the head |
| desc_dst_addr_o | output | 32 | Destination address |
| desc_src_addr_o | output | 32 | Source address |
| desc_xlen_o | output | 32 | X length minus one |
| desc_ylen_o | output | 32 | Y length minus one |
| desc_dst_stride_o | output | 32 | Destination stride |
| desc_src_stride_o | output | 32 | Source stride |
| done_valid_i | input | 1 | Mover reports a finished transfer |
| done_id_i | input | 5 | ID of the finished transfer |
| irq_o | output | 1 | Interrupt request |

## Verification
Register writes, and commits into a queue with room, show on the read port and on the descriptor outputs one edge after the write strobe. A commit blocked by a full queue enters on the edge after the pop that frees a slot. Done-mask bits and interrupt state follow a done pulse after one edge. The bench drives every input on a falling edge and reads the combinational outputs shortly after the next falling edge, so each check lands one whole edge after its stimulus. For the blocked commit, the start register is read both between the pop edge and the following edge and again after that edge.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int ID_W    = 5;
  localparam int NUM_IDS = 1 << ID_W;
  localparam int REG_AW  = 12;

  localparam logic [REG_AW-1:0] OFS_IRQ_MASK = 12'h080;
  localparam logic [REG_AW-1:0] OFS_IRQ_PEND = 12'h084;
  localparam logic [REG_AW-1:0] OFS_IRQ_SRC  = 12'h088;
  localparam logic [REG_AW-1:0] OFS_CTRL     = 12'h400;
  localparam logic [REG_AW-1:0] OFS_NEXT_ID  = 12'h404;
  localparam logic [REG_AW-1:0] OFS_START    = 12'h408;
  localparam logic [REG_AW-1:0] OFS_FLAGS    = 12'h40C;
  localparam logic [REG_AW-1:0] OFS_DST      = 12'h410;
  localparam logic [REG_AW-1:0] OFS_SRC      = 12'h414;
  localparam logic [REG_AW-1:0] OFS_XLEN     = 12'h418;
  localparam logic [REG_AW-1:0] OFS_YLEN     = 12'h41C;
  localparam logic [REG_AW-1:0] OFS_DSTRIDE  = 12'h420;
  localparam logic [REG_AW-1:0] OFS_SSTRIDE  = 12'h424;
  localparam logic [REG_AW-1:0] OFS_DONE     = 12'h428;
  localparam logic [REG_AW-1:0] OFS_ACTIVE   = 12'h42C;

  typedef enum int unsigned {EVT_SOT = 0, EVT_EOT = 1} irq_evt_e;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic [2:0]      flags;
    logic [31:0]     dst;
    logic [31:0]     src;
    logic [31:0]     xlen;
    logic [31:0]     ylen;
    logic [31:0]     dstride;
    logic [31:0]     sstride;
  } desc_t;
endpackage

// File: rtl/dmaq_fifo.sv
module dmaq_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= inc(wr_q);
      if (pop_i)  rd_q <= inc(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign data_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && full_o));
  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/dmaq_id_track.sv
module dmaq_id_track
  import dmaq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               alloc_i,
  input  logic               done_valid_i,
  input  logic [ID_W-1:0]    done_id_i,
  output logic [ID_W-1:0]    next_id_o,
  output logic [NUM_IDS-1:0] done_mask_o
);
  logic [ID_W-1:0] next_id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      next_id_q <= '0;
    else if (alloc_i) next_id_q <= next_id_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_done
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else if (done_valid_i && done_id_i == ID_W'(g)) bit_q <= 1'b1;
      else if (alloc_i && next_id_q == ID_W'(g))      bit_q <= 1'b0;
    end
    assign done_mask_o[g] = bit_q;
  end

  assign next_id_o = next_id_q;

  assert_id_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> next_id_o == ID_W'($past(next_id_o) + 5'd1));
  assert_reuse_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i && !(done_valid_i && done_id_i == next_id_o) |=> !done_mask_o[$past(next_id_o)]);
  assert_done_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_i |=> done_mask_o[$past(done_id_i)]);
endmodule

// File: rtl/dmaq_irq.sv
module dmaq_irq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] evt_i,
  input  logic       mask_we_i,
  input  logic [1:0] mask_i,
  input  logic       clr_we_i,
  input  logic [1:0] clr_i,
  output logic [1:0] mask_o,
  output logic [1:0] src_o,
  output logic [1:0] pend_o,
  output logic       irq_o
);
  logic [1:0] mask_q, src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 2'b11;
      src_q  <= 2'b00;
    end else begin
      if (mask_we_i) mask_q <= mask_i;
      src_q <= (src_q & ~(clr_we_i ? clr_i : 2'b00)) | evt_i;
    end
  end

  assign mask_o = mask_q;
  assign src_o  = src_q;
  assign pend_o = src_q & ~mask_q;
  assign irq_o  = |pend_o;

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i && clr_i == 2'b11 && evt_i == 2'b00 |=> !irq_o);
  assert_raise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[0] && !mask_o[0] && !mask_we_i |=> irq_o);
endmodule

// File: rtl/dmaq_regif.sv
module dmaq_regif
  import dmaq_pkg::*;
#(
  parameter int DEPTH           = 4,
  parameter int LEN_BITS        = 24,
  parameter int LEN_ALIGN_BITS  = 2,
  parameter int ADDR_ALIGN_BITS = 2,
  parameter bit HAS_2D          = 1'b1,
  parameter bit HAS_CYCLIC      = 1'b1,
  parameter bit HAS_PARTIAL     = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [11:0] reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        desc_valid_o,
  input  logic        desc_ready_i,
  output logic [4:0]  desc_id_o,
  output logic [2:0]  desc_flags_o,
  output logic [31:0] desc_dst_addr_o,
  output logic [31:0] desc_src_addr_o,
  output logic [31:0] desc_xlen_o,
  output logic [31:0] desc_ylen_o,
  output logic [31:0] desc_dst_stride_o,
  output logic [31:0] desc_src_stride_o,
  input  logic        done_valid_i,
  input  logic [4:0]  done_id_i,
  output logic        irq_o
);
  localparam logic [31:0] LEN_KEEP  = (LEN_BITS >= 32) ? '1 : ((32'd1 << LEN_BITS) - 32'd1);
  localparam logic [31:0] LEN_FORCE = (32'd1 << LEN_ALIGN_BITS) - 32'd1;
  localparam logic [31:0] ADR_KEEP  = ~((32'd1 << ADDR_ALIGN_BITS) - 32'd1);
  localparam logic [31:0] STR_KEEP  = LEN_KEEP & ADR_KEEP;
  localparam logic [2:0]  FLAG_KEEP = {HAS_PARTIAL, 1'b1, HAS_CYCLIC};
  localparam int          DW        = $bits(desc_t);

  logic [1:0]  ctrl_q;
  logic [2:0]  flags_q;
  logic [31:0] dst_q, src_q, xlen_q, ylen_q, dstride_q, sstride_q;
  logic        pend_q;

  logic ctrl_en, ctrl_pause;
  logic wr_ctrl, wr_start, flush, start_req, push, pop;
  logic fifo_empty, fifo_full;
  desc_t desc_in, desc_head;
  logic [ID_W-1:0]    next_id;
  logic [NUM_IDS-1:0] done_mask;
  logic [1:0] irq_mask, irq_src, irq_pend;

  function automatic logic sel(input logic [REG_AW-1:0] ofs);
    return reg_we_i && (reg_addr_i == ofs);
  endfunction

  assign ctrl_en    = ctrl_q[0];
  assign ctrl_pause = ctrl_q[1];
  assign wr_ctrl    = sel(OFS_CTRL);
  assign flush      = wr_ctrl && !reg_wdata_i[0];
  assign wr_start   = sel(OFS_START) && reg_wdata_i[0] && ctrl_en;
  assign start_req  = pend_q || wr_start;
  assign push       = ctrl_en && start_req && !fifo_full && !flush;
  assign pop        = desc_valid_o && desc_ready_i && !flush;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      flags_q   <= '0;
      dst_q     <= '0;
      src_q     <= '0;
      xlen_q    <= LEN_FORCE;
      dstride_q <= '0;
      sstride_q <= '0;
      pend_q    <= 1'b0;
    end else begin
      if (wr_ctrl)           ctrl_q    <= reg_wdata_i[1:0];
      if (sel(OFS_FLAGS))    flags_q   <= reg_wdata_i[2:0] & FLAG_KEEP;
      if (sel(OFS_DST))      dst_q     <= reg_wdata_i & ADR_KEEP;
      if (sel(OFS_SRC))      src_q     <= reg_wdata_i & ADR_KEEP;
      if (sel(OFS_XLEN))     xlen_q    <= (reg_wdata_i | LEN_FORCE) & LEN_KEEP;
      if (sel(OFS_DSTRIDE))  dstride_q <= reg_wdata_i & STR_KEEP;
      if (sel(OFS_SSTRIDE))  sstride_q <= reg_wdata_i & STR_KEEP;
      pend_q <= flush ? 1'b0 : (start_req && !push);
    end
  end

  if (HAS_2D) begin : g_2d
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           ylen_q <= '0;
      else if (sel(OFS_YLEN)) ylen_q <= reg_wdata_i & LEN_KEEP;
    end
  end else begin : g_1d
    assign ylen_q = '0;
  end

  always_comb begin
    desc_in         = '0;
    desc_in.id      = next_id;
    desc_in.flags   = flags_q;
    desc_in.dst     = dst_q;
    desc_in.src     = src_q;
    desc_in.xlen    = xlen_q;
    desc_in.ylen    = ylen_q;
    desc_in.dstride = dstride_q;
    desc_in.sstride = sstride_q;
  end

  dmaq_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (push),
    .data_i  (desc_in),
    .pop_i   (pop),
    .data_o  (desc_head),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  dmaq_id_track u_ids (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (push),
    .done_valid_i (done_valid_i),
    .done_id_i    (done_id_i),
    .next_id_o    (next_id),
    .done_mask_o  (done_mask)
  );

  logic [1:0] evt;
  assign evt[EVT_SOT] = push;
  assign evt[EVT_EOT] = done_valid_i;

  dmaq_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .mask_we_i (sel(OFS_IRQ_MASK)),
    .mask_i    (reg_wdata_i[1:0]),
    .clr_we_i  (sel(OFS_IRQ_PEND)),
    .clr_i     (reg_wdata_i[1:0]),
    .mask_o    (irq_mask),
    .src_o     (irq_src),
    .pend_o    (irq_pend),
    .irq_o     (irq_o)
  );

  assign desc_valid_o      = ctrl_en && !ctrl_pause && !fifo_empty;
  assign desc_id_o         = desc_head.id;
  assign desc_flags_o      = desc_head.flags;
  assign desc_dst_addr_o   = desc_head.dst;
  assign desc_src_addr_o   = desc_head.src;
  assign desc_xlen_o       = desc_head.xlen;
  assign desc_ylen_o       = desc_head.ylen;
  assign desc_dst_stride_o = desc_head.dstride;
  assign desc_src_stride_o = desc_head.sstride;

  always_comb begin
    case (reg_addr_i)
      OFS_IRQ_MASK: reg_rdata_o = {30'd0, irq_mask};
      OFS_IRQ_PEND: reg_rdata_o = {30'd0, irq_pend};
      OFS_IRQ_SRC:  reg_rdata_o = {30'd0, irq_src};
      OFS_CTRL:     reg_rdata_o = {30'd0, ctrl_q};
      OFS_NEXT_ID:  reg_rdata_o = 32'(next_id);
      OFS_START:    reg_rdata_o = {31'd0, pend_q};
      OFS_FLAGS:    reg_rdata_o = {29'd0, flags_q};
      OFS_DST:      reg_rdata_o = dst_q;
      OFS_SRC:      reg_rdata_o = src_q;
      OFS_XLEN:     reg_rdata_o = xlen_q;
      OFS_YLEN:     reg_rdata_o = ylen_q;
      OFS_DSTRIDE:  reg_rdata_o = dstride_q;
      OFS_SSTRIDE:  reg_rdata_o = sstride_q;
      OFS_DONE:     reg_rdata_o = 32'(done_mask);
      OFS_ACTIVE:   reg_rdata_o = 32'(fifo_empty ? next_id : desc_head.id);
      default:      reg_rdata_o = '0;
    endcase
  end

  assert_flush_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_en) |-> fifo_empty && !pend_q);
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && !desc_ready_i && !wr_ctrl |=> desc_valid_o && $stable(desc_id_o));
endmodule

// File: tb/dmaq_regif_tb.sv
module dmaq_regif_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        dv, ready = 1'b0;
  logic [4:0]  did;
  logic [2:0]  dflags;
  logic [31:0] ddst, dsrc, dxl, dyl, dds, dss;
  logic        done_v = 1'b0;
  logic [4:0]  done_id = '0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  logic [31:0] exp_done = '0;

  always #5 clk = ~clk;

  dmaq_regif dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .desc_valid_o(dv),
    .desc_ready_i(ready), .desc_id_o(did), .desc_flags_o(dflags),
    .desc_dst_addr_o(ddst), .desc_src_addr_o(dsrc), .desc_xlen_o(dxl),
    .desc_ylen_o(dyl), .desc_dst_stride_o(dds), .desc_src_stride_o(dss),
    .done_valid_i(done_v), .done_id_i(done_id), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic pulse_done(input logic [4:0] id);
    @(negedge clk);
    done_v = 1'b1; done_id = id;
    @(negedge clk);
    done_v = 1'b0;
    exp_done[id] = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rchk("R1 ctrl", 12'h400, 0);
    rchk("R1 mask", 12'h080, 3);
    rchk("R1 next id", 12'h404, 0);
    rchk("R1 done", 12'h428, 0);
    rchk("R1 start", 12'h408, 0);
    rchk("R1 xlen", 12'h418, 3);
    check("R1 irq", irq, 0);
    check("R1 valid", dv, 0);

    // R3 capability readback, R2 decode
    wr(12'h410, 32'h1234_5677); rchk("R3 dst align", 12'h410, 32'h1234_5674);
    wr(12'h418, 0);             rchk("R3 xlen zero", 12'h418, 3);
    wr(12'h418, '1);            rchk("R3 xlen top", 12'h418, 32'h00FF_FFFF);
    wr(12'h41C, '1);            rchk("R3 ylen top", 12'h41C, 32'h00FF_FFFF);
    wr(12'h40C, 7);             rchk("R3 flags", 12'h40C, 3);
    wr(12'h424, 32'hF100_1003); rchk("R3 sstride", 12'h424, 32'h0000_1000);
    wr(12'h420, 32'h0000_0047); rchk("R3 dstride", 12'h420, 32'h0000_0044);
    rchk("R2 unmapped", 12'h500, 0);
    rchk("R2 unaligned", 12'h402, 0);
    wr(12'h428, '1);            rchk("R8 done write ignored", 12'h428, 0);

    // R4 start ignored while disabled
    wr(12'h408, 1);
    rchk("R4 start disabled", 12'h408, 0);
    rchk("R4 next id disabled", 12'h404, 0);
    check("R4 valid disabled", dv, 0);

    // R5/R6 fill the queue while paused
    wr(12'h400, 3);
    for (int k = 0; k < 4; k++) begin
      wr(12'h410, 32'h1000 * k + 32'h100);
      wr(12'h418, 16 * k + 15);
      wr(12'h40C, k & 3);
      wr(12'h408, 1);
      rchk("R5 accepted", 12'h408, 0);
      rchk("R7 next id", 12'h404, k + 1);
      check("R6 paused holds", dv, 0);
    end
    wr(12'h408, 1);
    rchk("R5 full flag", 12'h408, 1);
    rchk("R7 next id full", 12'h404, 4);
    rchk("R9 active head", 12'h420 + 12'h00C, 0);
    rchk("R10 sot masked pend", 12'h084, 0);
    rchk("R10 sot src", 12'h088, 1);
    check("R10 irq masked", irq, 0);

    // R6 unpause and drain, fifth entry is the blocked commit
    wr(12'h400, 1);
    for (int k = 0; k < 5; k++) begin
      int s;
      s = (k < 4) ? k : 3;
      check("R6 valid", dv, 1);
      check("R6 id order", did, k);
      check("R6 dst", ddst, 32'h1000 * s + 32'h100);
      check("R6 xlen", dxl, 16 * s + 15);
      check("R6 flags", dflags, s & 3);
      @(negedge clk); ready = 1'b1;
      @(negedge clk); ready = 1'b0;
      if (k == 0) begin
        rchk("R5 still waiting after pop", 12'h408, 1);
        @(negedge clk);
        rchk("R5 taken next edge", 12'h408, 0);
        rchk("R7 id after late push", 12'h404, 5);
      end
    end
    check("R6 empty", dv, 0);
    rchk("R9 active empty", 12'h42C, 5);

    // R8 done and R10 irq
    pulse_done(2);
    rchk("R8 done bit", 12'h428, exp_done);
    rchk("R10 eot src", 12'h088, 3);
    wr(12'h080, 2);
    rchk("R10 pend", 12'h084, 1);
    check("R10 irq on", irq, 1);
    wr(12'h084, 1);
    rchk("R10 w1c src", 12'h088, 2);
    check("R10 irq off", irq, 0);
    wr(12'h080, 0);
    check("R10 irq eot", irq, 1);
    rchk("R10 pend eot", 12'h084, 2);
    wr(12'h084, 3);
    check("R10 irq cleared", irq, 0);
    rchk("R10 src cleared", 12'h088, 0);
    wr(12'h080, 3);

    // R7/R8 sweep across two ID wraps with a ready mover
    ready = 1'b1;
    for (int k = 5; k < 70; k++) begin
      wr(12'h410, k << 8);
      wr(12'h408, 1);
      exp_done[k % 32] = 1'b0;
      check("R6 sweep valid", dv, 1);
      check("R7 sweep id", did, k % 32);
      check("R6 sweep dst", ddst, k << 8);
      rchk("R8 reuse clears", 12'h428, exp_done);
      pulse_done(5'(k % 32));
      rchk("R8 sweep done", 12'h428, exp_done);
      rchk("R7 sweep next", 12'h404, (k + 1) % 32);
    end
    ready = 1'b0;

    // R4 flush with full queue and a waiting commit
    for (int k = 0; k < 5; k++) wr(12'h408, 1);
    rchk("R5 full again", 12'h408, 1);
    check("R9 valid before flush", dv, 1);
    wr(12'h400, 0);
    check("R4 flush valid", dv, 0);
    rchk("R4 flush start", 12'h408, 0);
    rchk("R4 next id kept", 12'h404, (70 + 4) % 32);
    rchk("R9 active after flush", 12'h42C, (70 + 4) % 32);
    rchk("R4 done kept", 12'h428, exp_done & ~(32'hF << 6));
    wr(12'h400, 1);
    check("R4 queue stays empty", dv, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule